// File: doc/BRIEF.md
# SPI Port with Fault Detection

This block is a one-byte serial peripheral port that works as either the clock-driving master or a clocked slave on an SPI bus. Software reaches it through three registers on a narrow parallel bus: a control register, a status register and a data register. In master mode it derives the serial clock from its own clock with a two-bit selectable divider, shifts a byte out most-significant bit first and samples the returned byte. Only clock polarity 0 and phase 0 is supported: the clock idles low, data changes on the falling edge and is sampled on the rising edge.

The slave-select pin takes one of four roles. A master can watch it for a mode fault, leave it alone as a spare pin, or drive it low for the length of each byte. A slave uses it as its active-low select. Four sticky status flags report finished transfers, writes that collide with a running transfer, bytes lost to overrun, and mode faults. Software clears each flag by writing a 1 to it. An interrupt output combines them when both the local and the global interrupt enables are set.

Register select: 0 is control, 1 is status, 2 is data. Control bits: [1:0] rate, [2] master, [3] select-output enable, [4] interrupt enable, [5] port enable. Status bits: [0] done, [1] collision, [2] overrun, [3] mode fault (these four are write-1-to-clear), [4] fault-detect disable (read/write).

Top module: `spi_fault_port`

## Requirements
- R1: After reset the control and status registers read 0, `irq` is low, `ssOe` is low and `sclkOut` is low.
- R2: In master mode one serial bit takes 16 << rate clock cycles (rate = control bits [1:0]), with the clock low for the first half and high for the second half. The clock idles low.
- R3: A master transfer sends the data-register byte MSB first on `mosiOut`, changing it only on falling clock edges. It samples `misoIn` on rising edges, and the received byte is then read from the data register.
- R4: With master = 1, fault-detect disable (status bit 4) = 1 and select-output enable (control bit 3) = 1, `ssOe` is high. `ssOut` is low for the whole byte and high once it ends.
- R5: With master = 1, fault-detect disable = 1 and select-output enable = 0, `ssOe` is low and a low level on `ssIn` raises no mode fault.
- R6: The done flag (status bit 0) is set when a byte completes and stays set until software writes 1 to status bit 0.
- R7: A data-register write while the done flag is set starts no transfer: no serial clock appears and the read buffer keeps its byte.
- R8: A data-register write during a running transfer sets the collision flag (status bit 1) and leaves the byte being shifted out unchanged. Writing 1 to status bit 1 clears the flag.
- R9: A byte that completes while the done flag is still set sets the overrun flag (status bit 2), and the read buffer keeps the older byte.
- R10: With master = 1 and fault-detect disable = 0, a low on `ssIn` sets the mode-fault flag (status bit 3) by the third rising clock edge. It also clears the master bit, stops driving the serial clock and leaves `ssOe` low.
- R11: `irq` equals `globalIrqEn` AND interrupt enable (control bit 4) AND (done OR overrun OR mode fault).
- R12: In slave mode, a low `ssIn` selects the port. It shifts in `mosiIn` on rising `sclkIn` edges and drives the loaded byte MSB first on `misoOut`, with `misoOe` high only while selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock, also the divider source |
| rstN | input | 1 | Asynchronous active-low reset |
| regSel | input | 2 | Register select: 0 control, 1 status, 2 data |
| wrEn | input | 1 | Register write strobe |
| wrData | input | DATA_W | Register write data |
| rdData | output | DATA_W | Read data of the selected register |
| globalIrqEn | input | 1 | Global interrupt enable |
| irq | output | 1 | Combined interrupt request |
| sclkIn | input | 1 | Serial clock from an external master |
| sclkOut | output | 1 | Serial clock driven in master mode |
| sclkOe | output | 1 | Serial clock output enable |
| ssIn | input | 1 | Slave-select pin level |
| ssOut | output | 1 | Automatic slave-select level |
| ssOe | output | 1 | Slave-select output enable |
| mosiIn | input | 1 | Serial data in for slave mode |
| mosiOut | output | 1 | Serial data out for master mode |
| mosiOe | output | 1 | Master data output enable |
| misoIn | input | 1 | Serial data in for master mode |
| misoOut | output | 1 | Serial data out for slave mode |
| misoOe | output | 1 | Slave data output enable |

## Verification
The bench runs master transfers at all four rates and measures the bit period. A divider that is off by one, or that treats the rate field as a plain count, would give the wrong cycle count per bit. It writes the data register in the middle of a byte: a design that reloaded the shifter would corrupt the outgoing byte, and one that dropped the flag would leave the collision bit low. It receives two slave bytes without clearing done, which exposes a buffer that is overwritten on overrun. It pulls the select pin low with fault detection on and with it off, which catches a port that keeps clocking after a fault or that faults while the pin is only a spare pin.

// File: rtl/spi_fault_pkg.sv
package spi_fault_pkg;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;

  // Status bit positions
  localparam int ST_DONE  = 0;
  localparam int ST_WCOL  = 1;
  localparam int ST_OVR   = 2;
  localparam int ST_MFLT  = 3;
  localparam int ST_MFDIS = 4;

  localparam int CTRL_W = 6;
  localparam int STAT_W = 5;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadTx;
    logic sampleBit;
    logic shiftBit;
    logic commitRx;
  } dpStrobe_t;

endpackage

// File: rtl/spi_fault_ctrl.sv
module spi_fault_ctrl
  import spi_fault_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int DIV_BASE_LOG2 = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        regSel,
  input  logic              wrEn,
  input  logic [CTRL_W-1:0] wrLow,
  input  logic              globalIrqEn,
  input  logic              sclkIn,
  input  logic              ssIn,
  input  logic              mosiIn,
  input  logic              misoIn,
  output dpStrobe_t         strb,
  output logic              rxBit,
  output logic [CTRL_W-1:0] ctrlBits,
  output logic [STAT_W-1:0] statBits,
  output logic              sclkOut,
  output logic              sclkOe,
  output logic              ssOut,
  output logic              ssOe,
  output logic              mosiOe,
  output logic              misoOe,
  output logic              irq
);

  localparam int CNT_W = DIV_BASE_LOG2 + 2;
  localparam int BIT_W = $clog2(DATA_W + 1);

  logic [1:0]       rate;
  logic             masterBit, ssOutEn, irqEn, enBit, mfDis;
  logic             done, wcol, ovr, mfault;
  logic             mBusy, sclkLvl;
  logic [CNT_W-1:0] divCnt, halfLimit;
  logic [BIT_W-1:0] bitCnt;
  logic [1:0]       ssSync, mosiSync;
  logic [2:0]       sclkSync;

  logic ctrlWr, statWr, dataWr;
  logic selected, slvRise, slvFall, busyNow, mfDet;
  logic halfEnd, mRise, mFall, lastBit, mDone, sDone, xferDone;
  logic startOk, wcolEv, autoSs;

  always_comb halfLimit = CNT_W'((32'd1 << (DIV_BASE_LOG2 - 1 + int'(rate))) - 32'd1);

  assign ctrlWr = wrEn && (regSel == ADDR_CTRL);
  assign statWr = wrEn && (regSel == ADDR_STAT);
  assign dataWr = wrEn && (regSel == ADDR_DATA);

  // Slave side: synchronised pins and edge detection
  assign selected = enBit && !masterBit && !ssSync[1];
  assign slvRise  = selected && sclkSync[1] && !sclkSync[2];
  assign slvFall  = selected && !sclkSync[1] && sclkSync[2];

  assign busyNow = masterBit ? mBusy : (selected && (bitCnt != '0));
  assign mfDet   = enBit && masterBit && !mfDis && !ssSync[1];

  // Master side: half-period ticks
  assign halfEnd = mBusy && (divCnt == halfLimit);
  assign mRise   = halfEnd && !sclkLvl;
  assign mFall   = halfEnd && sclkLvl;
  assign lastBit = (bitCnt == BIT_W'(DATA_W));
  assign mDone   = mFall && lastBit;
  assign sDone   = slvRise && (bitCnt == BIT_W'(DATA_W - 1));
  assign xferDone = (mDone || sDone) && !mfDet;

  assign startOk = dataWr && enBit && !done && !busyNow;
  assign wcolEv  = dataWr && enBit && !done && busyNow;

  always_comb begin
    strb.loadTx    = startOk;
    strb.sampleBit = (mRise || slvRise) && !mfDet;
    strb.shiftBit  = ((mFall && !lastBit) || slvFall) && !mfDet;
    strb.commitRx  = xferDone && !done;
  end

  assign rxBit = masterBit ? misoIn : mosiSync[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rate      <= '0;
      masterBit <= 1'b0;
      ssOutEn   <= 1'b0;
      irqEn     <= 1'b0;
      enBit     <= 1'b0;
      mfDis     <= 1'b0;
      done      <= 1'b0;
      wcol      <= 1'b0;
      ovr       <= 1'b0;
      mfault    <= 1'b0;
      mBusy     <= 1'b0;
      sclkLvl   <= 1'b0;
      divCnt    <= '0;
      bitCnt    <= '0;
      ssSync    <= 2'b11;
      mosiSync  <= '0;
      sclkSync  <= '0;
    end else begin
      ssSync   <= {ssSync[0], ssIn};
      mosiSync <= {mosiSync[0], mosiIn};
      sclkSync <= {sclkSync[1:0], sclkIn};

      if (ctrlWr) {enBit, irqEn, ssOutEn, masterBit, rate} <= wrLow;

      if (statWr) begin
        mfDis <= wrLow[ST_MFDIS];
        if (wrLow[ST_DONE]) done   <= 1'b0;
        if (wrLow[ST_WCOL]) wcol   <= 1'b0;
        if (wrLow[ST_OVR])  ovr    <= 1'b0;
        if (wrLow[ST_MFLT]) mfault <= 1'b0;
      end

      // Hardware set wins over a same-cycle software clear
      if (wcolEv) wcol <= 1'b1;
      if (xferDone) begin
        if (done) ovr  <= 1'b1;
        else      done <= 1'b1;
      end

      // Master sequencing
      if (startOk && masterBit) begin
        mBusy   <= 1'b1;
        divCnt  <= '0;
        sclkLvl <= 1'b0;
        bitCnt  <= '0;
      end else if (mBusy) begin
        if (halfEnd) begin
          divCnt  <= '0;
          sclkLvl <= !sclkLvl;
          if (mRise) bitCnt <= bitCnt + 1'b1;
          if (mDone) begin
            mBusy  <= 1'b0;
            bitCnt <= '0;
          end
        end else begin
          divCnt <= divCnt + 1'b1;
        end
      end

      // Slave bit counting
      if (!masterBit) begin
        if (!selected)    bitCnt <= '0;
        else if (slvRise) bitCnt <= sDone ? '0 : bitCnt + 1'b1;
      end

      if (!enBit) begin
        mBusy   <= 1'b0;
        sclkLvl <= 1'b0;
      end

      // Mode fault: drop to slave, stop the clock
      if (mfDet) begin
        mfault    <= 1'b1;
        masterBit <= 1'b0;
        mBusy     <= 1'b0;
        sclkLvl   <= 1'b0;
        bitCnt    <= '0;
        divCnt    <= '0;
      end
    end
  end

  assign autoSs   = masterBit && mfDis && ssOutEn;
  assign ctrlBits = {enBit, irqEn, ssOutEn, masterBit, rate};
  assign statBits = {mfDis, mfault, ovr, wcol, done};
  assign sclkOut  = sclkLvl;
  assign sclkOe   = enBit && masterBit;
  assign ssOe     = autoSs;
  assign ssOut    = !(autoSs && mBusy);
  assign mosiOe   = enBit && masterBit;
  assign misoOe   = selected;
  assign irq      = globalIrqEn && irqEn && (done || ovr || mfault);

  // R2: the serial clock level only moves at half-period ends
  p_sclk_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (mBusy && !halfEnd && !mfDet && enBit && !dataWr) |=> $stable(sclkOut));

  // R4: the automatic select is low whenever the clock is high
  p_ss_low_clocking_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ssOe && sclkOut) |-> !ssOut);

  // R6: done stays set unless software clears it
  p_done_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    (done && !(statWr && wrLow[ST_DONE])) |=> done);

  // R7: a write while done is set starts nothing
  p_blocked_write_r7: assert property (@(posedge clk) disable iff (!rstN)
    (dataWr && done && !mBusy) |=> !mBusy);

  // R8: a write while busy raises the collision flag
  p_wcol_set_r8: assert property (@(posedge clk) disable iff (!rstN)
    (dataWr && enBit && busyNow && !done) |=> wcol);

  // R10: a fault leaves the port out of master mode
  p_mfault_master_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mfault) |-> (!masterBit && !sclkOe));

endmodule

// File: rtl/spi_fault_dp.sv
module spi_fault_dp
  import spi_fault_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic              rxBit,
  input  logic [DATA_W-1:0] wrData,
  output logic              txBit,
  output logic [DATA_W-1:0] rxBuf
);

  logic [DATA_W-1:0] txShift, rxShift, rxNext;

  assign rxNext = strb.sampleBit ? {rxShift[DATA_W-2:0], rxBit} : rxShift;
  assign txBit  = txShift[DATA_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
      rxBuf   <= '0;
    end else begin
      if (strb.loadTx)        txShift <= wrData;
      else if (strb.shiftBit) txShift <= {txShift[DATA_W-2:0], 1'b0};
      rxShift <= rxNext;
      if (strb.commitRx) rxBuf <= rxNext;
    end
  end

  // R3: the outgoing bit holds unless a load or shift is requested
  p_tx_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.loadTx && !strb.shiftBit) |=> $stable(txBit));

endmodule

// File: rtl/spi_fault_port.sv
module spi_fault_port
  import spi_fault_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int DIV_BASE_LOG2 = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        regSel,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              globalIrqEn,
  output logic              irq,
  input  logic              sclkIn,
  output logic              sclkOut,
  output logic              sclkOe,
  input  logic              ssIn,
  output logic              ssOut,
  output logic              ssOe,
  input  logic              mosiIn,
  output logic              mosiOut,
  output logic              mosiOe,
  input  logic              misoIn,
  output logic              misoOut,
  output logic              misoOe
);

  dpStrobe_t         strb;
  logic              rxBit, txBit;
  logic [CTRL_W-1:0] ctrlBits;
  logic [STAT_W-1:0] statBits;
  logic [DATA_W-1:0] rxBuf;

  spi_fault_ctrl #(.DATA_W(DATA_W), .DIV_BASE_LOG2(DIV_BASE_LOG2)) u_ctrl (
    .clk(clk), .rstN(rstN), .regSel(regSel), .wrEn(wrEn),
    .wrLow(wrData[CTRL_W-1:0]), .globalIrqEn(globalIrqEn),
    .sclkIn(sclkIn), .ssIn(ssIn), .mosiIn(mosiIn), .misoIn(misoIn),
    .strb(strb), .rxBit(rxBit), .ctrlBits(ctrlBits), .statBits(statBits),
    .sclkOut(sclkOut), .sclkOe(sclkOe), .ssOut(ssOut), .ssOe(ssOe),
    .mosiOe(mosiOe), .misoOe(misoOe), .irq(irq)
  );

  spi_fault_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .rxBit(rxBit),
    .wrData(wrData), .txBit(txBit), .rxBuf(rxBuf)
  );

  assign mosiOut = txBit;
  assign misoOut = txBit;

  always_comb begin
    unique case (regSel)
      ADDR_CTRL: rdData = DATA_W'(ctrlBits);
      ADDR_STAT: rdData = DATA_W'(statBits);
      ADDR_DATA: rdData = rxBuf;
      default:   rdData = '0;
    endcase
  end

  // R9: when overrun is raised the read buffer was not overwritten
  p_ovr_keeps_buf_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statBits[ST_OVR]) |-> $stable(rxBuf));

endmodule

// File: tb/spi_fault_port_bench.sv
module spi_fault_port_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] A_CTRL = 2'd0, A_STAT = 2'd1, A_DATA = 2'd2;

  logic clk = 1'b0, rstN = 1'b0;
  logic [1:0] regSel = '0;
  logic wrEn = 1'b0, globalIrqEn = 1'b0;
  logic [7:0] wrData = '0, rdData;
  logic irq, sclkIn = 1'b0, sclkOut, sclkOe, ssIn = 1'b1, ssOut, ssOe;
  logic mosiIn = 1'b0, mosiOut, mosiOe, misoIn = 1'b0, misoOut, misoOe;

  int testCnt = 0, failCnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_fault_port u_spi_fault_port (
    .clk(clk), .rstN(rstN), .regSel(regSel), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .globalIrqEn(globalIrqEn), .irq(irq),
    .sclkIn(sclkIn), .sclkOut(sclkOut), .sclkOe(sclkOe),
    .ssIn(ssIn), .ssOut(ssOut), .ssOe(ssOe),
    .mosiIn(mosiIn), .mosiOut(mosiOut), .mosiOe(mosiOe),
    .misoIn(misoIn), .misoOut(misoOut), .misoOe(misoOe)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [7:0] v);
    @(negedge clk);
    regSel = a; wrData = v; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    regSel = a;
    #1 d = rdData;
  endtask

  // Acts as the remote slave while the port is master.
  task automatic masterXfer(input logic [7:0] tx, input logic [7:0] slv, input int collideAt,
                            output logic [7:0] mosiGot, output int period, output logic ssBad);
    int idx, rises, t1, cyc;
    logic prev;
    misoIn = slv[7]; idx = 6; rises = 0; t1 = 0; cyc = 0; period = 0;
    ssBad = 1'b0; mosiGot = '0;
    regWrite(A_DATA, tx);
    prev = sclkOut;
    while (!(rises == 8 && !sclkOut) && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (cyc == collideAt) begin regSel = A_DATA; wrData = 8'h00; wrEn = 1'b1; end
      if (cyc == collideAt + 1) wrEn = 1'b0;
      if (sclkOut && !prev) begin
        mosiGot = {mosiGot[6:0], mosiOut};
        rises++;
        if (rises == 1) t1 = cyc;
        if (rises == 2) period = cyc - t1;
        if (ssOut !== 1'b0) ssBad = 1'b1;
      end
      if (!sclkOut && prev && idx >= 0) begin misoIn = slv[idx]; idx--; end
      prev = sclkOut;
    end
    repeat (4) @(negedge clk);
  endtask

  // Acts as the remote master while the port is slave.
  task automatic slaveByte(input logic [7:0] b, output logic [7:0] misoGot);
    misoGot = '0;
    for (int i = 7; i >= 0; i--) begin
      mosiIn = b[i];
      repeat (8) @(negedge clk);
      misoGot = {misoGot[6:0], misoOut};
      sclkIn = 1'b1;
      repeat (8) @(negedge clk);
      sclkIn = 1'b0;
    end
    repeat (8) @(negedge clk);
  endtask

  task automatic tReset();
    logic [7:0] d;
    regRead(A_CTRL, d); check("R1 ctrl after reset", d, 8'h00);
    regRead(A_STAT, d); check("R1 status after reset", d, 8'h00);
    check("R1 irq after reset", irq, 1'b0);
    check("R1 ssOe after reset", ssOe, 1'b0);
    check("R1 sclkOut after reset", sclkOut, 1'b0);
  endtask

  task automatic tMasterRates();
    logic [7:0] txs [4] = '{8'hA5, 8'h3C, 8'h81, 8'hF0};
    logic [7:0] sls [4] = '{8'h5A, 8'hC3, 8'h7E, 8'h0F};
    logic [7:0] got, d;
    int per;
    logic ssBad;
    regWrite(A_STAT, 8'h10);
    for (int r = 0; r < 4; r++) begin
      regWrite(A_CTRL, 8'h2C | 8'(r));
      masterXfer(txs[r], sls[r], -5, got, per, ssBad);
      check("R2 bit period", per, 32'(16 << r));
      check("R3 MSB-first byte on mosi", got, txs[r]);
      regRead(A_DATA, d); check("R3 received byte", d, sls[r]);
      check("R4 select low during byte", ssBad, 1'b0);
      check("R4 ssOe with auto select", ssOe, 1'b1);
      check("R4 select high after byte", ssOut, 1'b1);
      check("R2 clock idles low", sclkOut, 1'b0);
      repeat (50) @(negedge clk);
      regRead(A_STAT, d); check("R6 done sticky", d[0], 1'b1);
      regWrite(A_STAT, 8'h11);
      regRead(A_STAT, d); check("R6 done cleared by write 1", d[0], 1'b0);
    end
  endtask

  task automatic tBlocked();
    logic [7:0] got, d;
    int per;
    logic ssBad, sawClk;
    regWrite(A_CTRL, 8'h2C);
    masterXfer(8'h66, 8'h99, -5, got, per, ssBad);
    regWrite(A_DATA, 8'h11);
    sawClk = 1'b0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (sclkOut) sawClk = 1'b1;
    end
    check("R7 no clock while done set", sawClk, 1'b0);
    check("R7 select stays high", ssOut, 1'b1);
    regRead(A_DATA, d); check("R7 read buffer unchanged", d, 8'h99);
    regWrite(A_STAT, 8'h11);
  endtask

  task automatic tWcol();
    logic [7:0] got, d;
    int per;
    logic ssBad;
    regWrite(A_CTRL, 8'h2C);
    masterXfer(8'hC5, 8'h18, 40, got, per, ssBad);
    regRead(A_STAT, d); check("R8 collision flag set", d[1], 1'b1);
    check("R8 outgoing byte intact", got, 8'hC5);
    regWrite(A_STAT, 8'h13);
    regRead(A_STAT, d); check("R8 collision flag cleared", d[1:0], 2'b00);
  endtask

  task automatic tGpPin();
    logic [7:0] got, d;
    int per;
    logic ssBad;
    regWrite(A_STAT, 8'h10);
    regWrite(A_CTRL, 8'h24);
    ssIn = 1'b0;
    masterXfer(8'h42, 8'h24, -5, got, per, ssBad);
    check("R5 ssOe low for spare pin", ssOe, 1'b0);
    regRead(A_STAT, d); check("R5 no mode fault, done set", d[3:0], 4'b0001);
    check("R5 byte still sent", got, 8'h42);
    ssIn = 1'b1;
    regWrite(A_STAT, 8'h11);
  endtask

  task automatic tModeFault();
    logic [7:0] d;
    regWrite(A_STAT, 8'h0F);
    globalIrqEn = 1'b0;
    regWrite(A_CTRL, 8'h34);
    regWrite(A_DATA, 8'hAA);
    repeat (30) @(negedge clk);
    ssIn = 1'b0;
    repeat (4) @(negedge clk);
    regRead(A_STAT, d); check("R10 mode fault flag", d[3], 1'b1);
    regRead(A_CTRL, d); check("R10 master bit cleared", d, 8'h30);
    check("R10 clock not driven", sclkOe, 1'b0);
    check("R10 clock low", sclkOut, 1'b0);
    check("R10 ssOe low", ssOe, 1'b0);
    check("R11 irq gated by global enable", irq, 1'b0);
    globalIrqEn = 1'b1;
    #1 check("R11 irq on mode fault", irq, 1'b1);
    ssIn = 1'b1;
    regWrite(A_STAT, 8'h08);
    #1 check("R11 irq drops after clear", irq, 1'b0);
    globalIrqEn = 1'b0;
  endtask

  task automatic tSlave();
    logic [7:0] got, d;
    regWrite(A_STAT, 8'h1F);
    regWrite(A_CTRL, 8'h20);
    check("R12 misoOe low when not selected", misoOe, 1'b0);
    ssIn = 1'b0;
    repeat (4) @(negedge clk);
    regWrite(A_DATA, 8'h96);
    check("R12 misoOe high when selected", misoOe, 1'b1);
    slaveByte(8'h3B, got);
    check("R12 slave drives loaded byte", got, 8'h96);
    regRead(A_STAT, d); check("R12 slave done", d[2:0], 3'b001);
    regRead(A_DATA, d); check("R12 slave received byte", d, 8'h3B);
    slaveByte(8'hE4, got);
    regRead(A_STAT, d); check("R9 overrun flag", d[2], 1'b1);
    regRead(A_DATA, d); check("R9 buffer keeps older byte", d, 8'h3B);
    globalIrqEn = 1'b1;
    regWrite(A_STAT, 8'h11);
    regWrite(A_CTRL, 8'h30);
    #1 check("R11 irq on overrun alone", irq, 1'b1);
    ssIn = 1'b1;
    repeat (4) @(negedge clk);
    check("R12 misoOe released", misoOe, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog R1: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tReset();
    tMasterRates();
    tBlocked();
    tWcol();
    tGpPin();
    tModeFault();
    tSlave();
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule